// File: doc/BRIEF.md
# Synchronous Clock Stop Gate

This block turns three groups of free-running clocks on and off without ever producing a short pulse. The first group is the processor clocks. The second is a small set of normally free-running bus clocks. The third is the ordinary bus clocks. Each group is modelled as an enable-qualified toggle in one fast system clock domain. A half-period counter drives each toggle, and a per-output run flop gates it. A run flop may change only on the edge where its clock falls. As a result, an output always stops in the low state, and a restarted output always begins with a full-width high phase.

Two active-low stop pins and an active-low power-down pin control the gating. The stop pins arrive asynchronously and pass through a two-flop synchronizer. They are then sampled on the rising phase of the internal free-running bus clock. The processor stop pin reaches the processor group. The bus stop pin reaches the ordinary bus group. It also reaches those free-running bus outputs whose obey bit is set. Each processor output has an obey bit as well: 0 lets it run through a stop request, and 1 lets the request stop it. Every output has its own enable bit. Power-down parks every output, whatever the enable and obey bits say.

Top module: `cgate_stop_ctrl`

## Requirements
- R1: The two stop pins are synchronized through two flops. Their state is taken only at a rising phase of the internal bus clock.
- R2: A stopped, disabled or powered-down output is held at logic 0. During reset all outputs are 0.
- R3: Every high phase of an output lasts exactly its half period. This is CPU_HALF system cycles for the processor outputs and PCI_HALF for both bus groups. This also holds for the first pulse after a restart.
- R4: After cpu_stop_n changes, each obeying processor output stops or restarts within SYNC_STAGES + 2*PCI_HALF + 8*CPU_HALF system cycles. That is under four processor periods once the request has been sampled.
- R5: After pci_stop_n changes, each ordinary bus output stops or restarts within SYNC_STAGES + 2*PCI_HALF + 4*PCI_HALF system cycles. That is under two bus periods once the request has been sampled.
- R6: While one group is stopped by its stop pin, all outputs not governed by that pin keep toggling.
- R7: The cpu_obey bit i and the pcif_obey bit i apply to output i of their group. A value of 1 means the output follows its stop pin, and 0 means it ignores the pin. The ordinary bus outputs always follow pci_stop_n.
- R8: The enable bit i of each group applies to output i of that group. A value of 1 lets it run and 0 parks it low.
- R9: While pwr_dn_n is low, every output of every group is parked low.
- R10: A run flop changes only on the edge where its clock goes low. A gating change is therefore never visible while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_stop_n | input | 1 | Asynchronous active-low stop request for processor clocks |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for bus clocks |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down, parks all outputs |
| cpu_en | input | NUM_CPU | Per-output enable, processor group |
| cpu_obey | input | NUM_CPU | Per-output stop obey bit, processor group |
| pcif_en | input | NUM_PCIF | Per-output enable, free-running bus group |
| pcif_obey | input | NUM_PCIF | Per-output stop obey bit, free-running bus group |
| pci_en | input | NUM_PCI | Per-output enable, ordinary bus group |
| cpu_clk_o | output | NUM_CPU | Gated processor clocks |
| pcif_clk_o | output | NUM_PCIF | Gated free-running bus clocks |
| pci_clk_o | output | NUM_PCI | Gated ordinary bus clocks |

## Verification
A run flop that changes during a high phase shows up at the port at once. It appears as a high phase shorter or longer than its half period, or as a rise that does not line up with the clock's rising tick. The pulse-width observer catches it on the falling edge of that same pulse. A stuck or mis-sampled stop request shows up differently. Outputs keep toggling, or stay parked, beyond the stated latency bound. The scoreboard window, which spans two bus periods, then reports the wrong group state. An obey or enable bit routed to the wrong output shows as a single wrong bit in the group's run pattern within one settle window.

// File: rtl/cgate_pkg.sv
package cgate_pkg;

   // Phase of one internally generated clock: current level and the
   // one-cycle ticks that precede a falling or a rising transition.
   typedef struct packed {
      logic level;
      logic fall;
      logic rise;
   } phase_t;

   function automatic int unsigned cnt_width(int unsigned span);
      return (span < 2) ? 1 : $clog2(span);
   endfunction

endpackage

// File: rtl/cgate_sync.sv
module cgate_sync #(
   parameter int unsigned W          = 1,
   parameter int unsigned STAGES     = 2,
   parameter logic [W-1:0] RST_VAL   = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cgate_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("cgate_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cgate_phase.sv
module cgate_phase
   import cgate_pkg::*;
#(
   parameter int unsigned HALF = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   output phase_t ph_o
);

   if (HALF < 1) begin : g_bad_half
      $error("cgate_phase: HALF must be at least 1");
   end

   localparam int unsigned CW = cnt_width(HALF);
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          level_q;
   logic          term;

   assign term = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         level_q <= 1'b0;
      end else if (term) begin
         cnt_q   <= '0;
         level_q <= ~level_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign ph_o.level = level_q;
   assign ph_o.fall  = level_q & term;
   assign ph_o.rise  = ~level_q & term;

endmodule

// File: rtl/cgate_lane.sv
module cgate_lane
   import cgate_pkg::*;
#(
   parameter int unsigned N    = 2,
   parameter int unsigned HALF = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  phase_t       ph_i,
   input  logic [N-1:0] want_i,
   output logic [N-1:0] gclk_o
);

   if (N < 1) begin : g_bad_n
      $error("cgate_lane: N must be at least 1");
   end

   localparam int unsigned CW = cnt_width(HALF + 2);
   localparam logic [CW-1:0] HALF_V = CW'(HALF);

   logic [N-1:0] run_q;

   // Run flops move only with the falling tick, so the level they gate
   // is low from that edge on and every high phase is left whole.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= '0;
      else if (ph_i.fall) run_q <= want_i;
   end

   assign gclk_o = {N{ph_i.level}} & run_q;

   for (genvar i = 0; i < N; i++) begin : g_out
      logic [CW-1:0] hi_cnt;
      logic [CW-1:0] lo_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
         end else if (gclk_o[i]) begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
            if (lo_cnt < HALF_V) lo_cnt <= lo_cnt + 1'b1;
         end
      end

      AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(gclk_o[i]) |-> hi_cnt == HALF_V);                        // R3
      AST_FULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gclk_o[i]) |-> lo_cnt >= HALF_V);                        // R3
      AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gclk_o[i]) |-> $past(ph_i.rise));                        // R3
      AST_GATE_CHANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(run_q[i]) |-> !ph_i.level);                           // R10
   end

endmodule

// File: rtl/cgate_stop_ctrl.sv
module cgate_stop_ctrl
   import cgate_pkg::*;
#(
   parameter int unsigned NUM_CPU     = 2,
   parameter int unsigned NUM_PCIF    = 2,
   parameter int unsigned NUM_PCI     = 6,
   parameter int unsigned CPU_HALF    = 2,
   parameter int unsigned PCI_HALF    = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_stop_n,
   input  logic                pci_stop_n,
   input  logic                pwr_dn_n,
   input  logic [NUM_CPU-1:0]  cpu_en,
   input  logic [NUM_CPU-1:0]  cpu_obey,
   input  logic [NUM_PCIF-1:0] pcif_en,
   input  logic [NUM_PCIF-1:0] pcif_obey,
   input  logic [NUM_PCI-1:0]  pci_en,
   output logic [NUM_CPU-1:0]  cpu_clk_o,
   output logic [NUM_PCIF-1:0] pcif_clk_o,
   output logic [NUM_PCI-1:0]  pci_clk_o
);

   if (NUM_CPU < 1 || NUM_PCIF < 1 || NUM_PCI < 1) begin : g_bad_groups
      $error("cgate_stop_ctrl: every group needs at least one output");
   end
   if (PCI_HALF < CPU_HALF) begin : g_bad_ratio
      $error("cgate_stop_ctrl: bus clock must not be faster than processor clock");
   end

   localparam int unsigned NPIN = 3;
   localparam int unsigned P_CPU = 0;
   localparam int unsigned P_PCI = 1;
   localparam int unsigned P_PWR = 2;

   // pin synchronizer, all inputs idle high
   logic [NPIN-1:0] pin_sync;

   cgate_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
      .q_o   (pin_sync)
   );

   // internal free-running clock phases
   phase_t cpu_ph;
   phase_t pci_ph;

   cgate_phase #(.HALF(CPU_HALF)) u_cpu_phase (
      .clk (clk), .rst_n (rst_n), .ph_o (cpu_ph)
   );
   cgate_phase #(.HALF(PCI_HALF)) u_pci_phase (
      .clk (clk), .rst_n (rst_n), .ph_o (pci_ph)
   );

   // stop requests taken on the rising phase of the free-running bus clock
   logic cpu_stop_q;
   logic pci_stop_q;
   logic pwr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_stop_q <= 1'b0;
         pci_stop_q <= 1'b0;
      end else if (pci_ph.rise) begin
         cpu_stop_q <= ~pin_sync[P_CPU];
         pci_stop_q <= ~pin_sync[P_PCI];
      end
   end

   assign pwr_ok = pin_sync[P_PWR];

   // per-output run wishes
   logic [NUM_CPU-1:0]  cpu_want;
   logic [NUM_PCIF-1:0] pcif_want;
   logic [NUM_PCI-1:0]  pci_want;

   assign cpu_want  = cpu_en  & ~(cpu_obey  & {NUM_CPU{cpu_stop_q}})  & {NUM_CPU{pwr_ok}};
   assign pcif_want = pcif_en & ~(pcif_obey & {NUM_PCIF{pci_stop_q}}) & {NUM_PCIF{pwr_ok}};
   assign pci_want  = pci_en  & ~{NUM_PCI{pci_stop_q}}                & {NUM_PCI{pwr_ok}};

   cgate_lane #(.N(NUM_CPU), .HALF(CPU_HALF)) u_cpu_lane (
      .clk (clk), .rst_n (rst_n), .ph_i (cpu_ph), .want_i (cpu_want), .gclk_o (cpu_clk_o)
   );
   cgate_lane #(.N(NUM_PCIF), .HALF(PCI_HALF)) u_pcif_lane (
      .clk (clk), .rst_n (rst_n), .ph_i (pci_ph), .want_i (pcif_want), .gclk_o (pcif_clk_o)
   );
   cgate_lane #(.N(NUM_PCI), .HALF(PCI_HALF)) u_pci_lane (
      .clk (clk), .rst_n (rst_n), .ph_i (pci_ph), .want_i (pci_want), .gclk_o (pci_clk_o)
   );

   AST_SAMPLE_ON_PCI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({cpu_stop_q, pci_stop_q}) |-> $past(pci_ph.rise));                  // R1
   AST_PWRDN_PARK_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!pwr_ok && cpu_ph.fall) |-> cpu_clk_o == '0);                          // R9
   AST_PWRDN_PARK_PCI: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!pwr_ok && pci_ph.fall) |-> (pci_clk_o == '0 && pcif_clk_o == '0));    // R9
   AST_CPU_OBEY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cpu_ph.fall) |-> (cpu_clk_o & $past(cpu_obey & {NUM_CPU{cpu_stop_q}})) == '0); // R7

endmodule

// File: tb/test_cgate_stop_ctrl.sv
module test_cgate_stop_ctrl;

   localparam int NC = 2;
   localparam int NF = 2;
   localparam int NP = 6;
   localparam int CH = 2;
   localparam int PH = 6;
   localparam int SS = 2;
   localparam int NA = NC + NF + NP;
   localparam int CPU_BOUND = SS + 2*PH + 8*CH;
   localparam int PCI_BOUND = SS + 2*PH + 4*PH;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          cpu_stop_n = 1'b1;
   logic          pci_stop_n = 1'b1;
   logic          pwr_dn_n   = 1'b1;
   logic [NC-1:0] cpu_en     = '1;
   logic [NC-1:0] cpu_obey   = '1;
   logic [NF-1:0] pcif_en    = '1;
   logic [NF-1:0] pcif_obey  = '0;
   logic [NP-1:0] pci_en     = '1;
   logic [NC-1:0] cpu_clk_o;
   logic [NF-1:0] pcif_clk_o;
   logic [NP-1:0] pci_clk_o;

   cgate_stop_ctrl #(
      .NUM_CPU(NC), .NUM_PCIF(NF), .NUM_PCI(NP),
      .CPU_HALF(CH), .PCI_HALF(PH), .SYNC_STAGES(SS)
   ) i_cgate_stop_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
      .cpu_en(cpu_en), .cpu_obey(cpu_obey),
      .pcif_en(pcif_en), .pcif_obey(pcif_obey), .pci_en(pci_en),
      .cpu_clk_o(cpu_clk_o), .pcif_clk_o(pcif_clk_o), .pci_clk_o(pci_clk_o)
   );

   logic [NA-1:0] allv;
   assign allv = {pci_clk_o, pcif_clk_o, cpu_clk_o};

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string         tag;
      logic [NA-1:0] exp_run;
   } sb_item_t;

   sb_item_t sb_q[$];
   bit mon_busy = 1'b0;

   function automatic int half_of(int b);
      return (b < NC) ? CH : PH;
   endfunction

   function automatic logic [NA-1:0] pat(logic [NP-1:0] p, logic [NF-1:0] f, logic [NC-1:0] c);
      return {p, f, c};
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard: let the change settle, then hand over
   task automatic expect_state(string tag, logic [NA-1:0] exp);
      sb_item_t it;
      repeat (PCI_BOUND + 12) @(negedge clk);
      it.tag = tag;
      it.exp_run = exp;
      sb_q.push_back(it);
      wait (sb_q.size() == 0 && !mon_busy);
      @(negedge clk);
   endtask

   task automatic lat_off(int b, int bound, string tag);
      int last = 0;
      for (int k = 1; k <= bound + 4*PH; k++) begin
         @(negedge clk);
         if (allv[b]) last = k;
      end
      check(last <= bound, tag, last, bound);
   endtask

   task automatic lat_on(int b, int bound, string tag);
      int first = -1;
      for (int k = 1; k <= bound + 4*PH; k++) begin
         @(negedge clk);
         if (allv[b] && first < 0) first = k;
      end
      check(first > 0 && first <= bound, tag, first, bound);
   endtask

   // monitor side of the scoreboard
   initial begin
      sb_item_t      it;
      logic [NA-1:0] toggled;
      logic [NA-1:0] seen_hi;
      logic [NA-1:0] prev;
      forever begin
         wait (sb_q.size() > 0);
         mon_busy = 1'b1;
         it = sb_q.pop_front();
         toggled = '0;
         seen_hi = '0;
         prev = allv;
         repeat (4*PH) begin
            @(negedge clk);
            toggled |= allv ^ prev;
            seen_hi |= allv;
            prev = allv;
         end
         check(toggled == it.exp_run && (seen_hi & ~it.exp_run) == '0,
               it.tag, int'(toggled), int'(it.exp_run));
         mon_busy = 1'b0;
      end
   end

   // every high phase must be exactly one half period (R3, R10)
   initial begin
      int hl[NA];
      hl = '{default: 0};
      forever begin
         @(negedge clk);
         if (rst_n) begin
            for (int b = 0; b < NA; b++) begin
               if (allv[b]) hl[b]++;
               else begin
                  if (hl[b] != 0) check(hl[b] == half_of(b), "R3 R10 high width", hl[b], half_of(b));
                  hl[b] = 0;
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check(allv == '0, "R2 reset parks low", int'(allv), 0);
      rst_n = 1'b1;

      expect_state("R8 all enabled run", '1);

      // processor stop, both pairs obey
      @(negedge clk);
      cpu_stop_n = 1'b0;
      lat_off(0, CPU_BOUND, "R1 R4 cpu stop latency");
      expect_state("R2 R6 cpu stopped others run", pat('1, '1, 2'b00));
      @(negedge clk);
      cpu_stop_n = 1'b1;
      lat_on(1, CPU_BOUND, "R4 cpu restart latency");
      expect_state("R4 cpu restarted", '1);

      // one processor pair set to free-run
      @(negedge clk);
      cpu_obey = 2'b01;
      cpu_stop_n = 1'b0;
      expect_state("R7 cpu obey mask", pat('1, '1, 2'b10));
      cpu_stop_n = 1'b1;
      cpu_obey = 2'b11;
      expect_state("R7 cpu mask restore", '1);

      // bus stop, free-running bus outputs ignore it
      @(negedge clk);
      pci_stop_n = 1'b0;
      lat_off(NC + NF, PCI_BOUND, "R1 R5 pci stop latency");
      expect_state("R5 R6 R7 pci stopped", pat('0, 2'b11, '1));
      pcif_obey = 2'b10;
      expect_state("R7 pcif obey mask", pat('0, 2'b01, '1));
      @(negedge clk);
      pci_stop_n = 1'b1;
      lat_on(NC + NF + 2, PCI_BOUND, "R5 pci restart latency");
      pcif_obey = 2'b00;
      expect_state("R5 pci restarted", '1);

      // both stops at once with free-run masks
      cpu_obey = 2'b10;
      cpu_stop_n = 1'b0;
      pci_stop_n = 1'b0;
      expect_state("R6 R7 both stops", pat('0, 2'b11, 2'b01));
      cpu_stop_n = 1'b1;
      pci_stop_n = 1'b1;
      cpu_obey = 2'b11;

      // individual enables
      cpu_en  = 2'b10;
      pcif_en = 2'b01;
      pci_en  = 6'b101010;
      expect_state("R8 enable pattern", pat(6'b101010, 2'b01, 2'b10));
      cpu_en  = '1;
      pcif_en = '1;
      pci_en  = '1;
      expect_state("R8 enables restored", '1);

      // power-down overrides everything
      @(negedge clk);
      pwr_dn_n = 1'b0;
      lat_off(NC, PCI_BOUND, "R9 power-down latency");
      expect_state("R2 R9 power-down all low", '0);
      pwr_dn_n = 1'b1;
      expect_state("R9 power restored", '1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule